// File: doc/BRIEF.md
# Dual Data Buffer Access Port

This block gives a host processor word-wide access to the two 512-byte staging buffers that a memory-card host controller uses for single-block transfers. Each buffer holds 64 words of 64 bits. The host sees two registers on a simple 64-bit register bus. The index register holds a buffer select, a word offset and an auto-increment enable. The data register moves one word at the buffer location the index points to. When auto-increment is on, every data-register access advances the offset by one, so a block can be streamed with back-to-back data accesses after a single index write.

The card-side logic reaches the same storage through its own port, which addresses a buffer and a word directly. A host data access and a card access to the same buffer in one cycle are resolved in favour of the host, and the block raises a one-cycle error flag. Transfers shorter than a full buffer are aligned to the end of the buffer. A small calculator turns a byte count into the word offset at which the card side should start.

Bytes are packed big-endian. The first byte of a transfer sits in bits 63:56 of its word, and later bytes follow in descending byte lanes.

Top module: `dbuf_access_port`

## Requirements
- R1: After reset the index is zero (auto-increment off, buffer 0, offset 0), `hst_rvalid` and `crd_conflict` are low, and `hst_rdata` and `crd_rdata` read zero.
- R2: A write to the index register (`hst_addr`=0) loads auto-increment from bit 16, the buffer select from bit 6 and the word offset from bits 5:0, and ignores all other bits. An index read returns those three fields in the same positions, with zeros elsewhere.
- R3: A data-register access (`hst_addr`=1) writes or reads exactly one 64-bit word at the selected buffer and offset. The word is stored unchanged, so a byte placed in bits 63:56 is the first byte of the transfer as seen by the card side.
- R4: With auto-increment set, the offset advances by one after each data read or data write. With it clear, the offset does not change.
- R5: Auto-increment wraps the offset from 63 to 0 inside the same buffer and never changes the buffer select.
- R6: Index reads never change the index.
- R7: Any host read returns its data on `hst_rdata`, with `hst_rvalid` high, in the cycle after the request. A card read returns its word on `crd_rdata` in the cycle after `crd_en`. Card writes update the same storage the host reads.
- R8: When a host data access and a card access hit the same buffer in one cycle, the host access completes, a card write is dropped, a card read returns zero, and `crd_conflict` is high in the following cycle. Accesses to different buffers never conflict.
- R9: `xfer_start_word` equals (64 − ceil(N/8)) mod 64 for a byte count N on `xfer_bytes`. This gives 0 for 512 bytes and 63 for 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | Host register access strobe |
| hst_wr | input | 1 | Host access is a write |
| hst_addr | input | 1 | Register select: 0 index, 1 data |
| hst_wdata | input | 64 | Host write data |
| hst_rdata | output | 64 | Host read data |
| hst_rvalid | output | 1 | Host read data valid |
| crd_en | input | 1 | Card-side access strobe |
| crd_we | input | 1 | Card-side write |
| crd_buf | input | 1 | Card-side buffer number |
| crd_word | input | 6 | Card-side word address |
| crd_wdata | input | 64 | Card-side write data |
| crd_rdata | output | 64 | Card-side read data |
| crd_conflict | output | 1 | Same-buffer collision flag, one cycle after it happens |
| xfer_bytes | input | 10 | Transfer length in bytes |
| xfer_start_word | output | 6 | Card-side starting word for that length |

## Verification
The bench drives the offset across the 63 boundary with auto-increment on. A design that carried into the select bit would land in the other buffer, and a design that saturated would overwrite word 63. It writes index values full of stray set bits, which catches field decoders that take the wrong positions or keep extra bits. It also checks that index reads and data accesses with auto-increment clear leave the offset alone. Same-buffer collisions are aimed at both write and read. A design that let the card win, or merged the two accesses, would show a corrupted word on a later host read, or non-zero card read data. Random mixes of the two ports are compared against a reference model, and several lengths are checked for the start-word calculation, including the full-buffer case that must wrap to 0.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
    localparam int unsigned DBUF_NUM_BUFS = 2;
    localparam int unsigned DBUF_WORDS    = 64;
    localparam int unsigned DBUF_DATA_W   = 64;
    localparam int unsigned DBUF_AUTO_BIT = 16;
    localparam int unsigned DBUF_SEL_LSB  = 6;

    typedef enum logic {
        HREG_INDEX = 1'b0,
        HREG_DATA  = 1'b1
    } hreg_e;
endpackage

// File: rtl/dbuf_index_reg.sv
module dbuf_index_reg #(
    parameter int unsigned SEL_W = 1,
    parameter int unsigned OFF_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic             ld_auto,
    input  logic [SEL_W-1:0] ld_sel,
    input  logic [OFF_W-1:0] ld_off,
    input  logic             step,
    output logic             auto_o,
    output logic [SEL_W-1:0] sel_o,
    output logic [OFF_W-1:0] off_o
);
    typedef struct packed {
        logic             auto_en;
        logic [SEL_W-1:0] sel;
        logic [OFF_W-1:0] off;
    } idx_t;

    idx_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.auto_en = ld_auto;
            st_d.sel     = ld_sel;
            st_d.off     = ld_off;
        end else if (step && st_q.auto_en) begin
            // offset field wraps on its own width; select is untouched
            st_d.off = st_q.off + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign auto_o = st_q.auto_en;
    assign sel_o  = st_q.sel;
    assign off_o  = st_q.off;

    // R5
    off_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && step && st_q.auto_en && (&st_q.off)) |=> (st_q.off == '0 && $stable(st_q.sel)));

    // R4
    idx_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && step && st_q.auto_en) |=> (st_q.off == OFF_W'($past(st_q.off) + 1'b1)));

    // R6
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !step) |=> $stable(st_q));
endmodule

// File: rtl/dbuf_bank.sv
module dbuf_bank #(
    parameter int unsigned WORDS  = 64,
    parameter int unsigned DATA_W = 64,
    localparam int unsigned AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (en && !we) rdata_d = mem[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    always_ff @(posedge clk) begin
        if (en && we) mem[addr] <= wdata;
    end

    assign rdata = rdata_q;

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && !we) |=> $stable(rdata_q));
endmodule

// File: rtl/dbuf_start_calc.sv
module dbuf_start_calc #(
    parameter int unsigned WORDS = 64,
    parameter int unsigned LEN_W = 10,
    localparam int unsigned OFF_W = $clog2(WORDS)
) (
    input  logic [LEN_W-1:0] nbytes,
    output logic [OFF_W-1:0] start_word
);
    logic [LEN_W-1:0] rounded_d;
    logic [LEN_W-4:0] words_d;

    always_comb begin
        rounded_d  = nbytes + LEN_W'(7);
        words_d    = rounded_d[LEN_W-1:3];
        start_word = OFF_W'(WORDS - words_d);
    end
endmodule

// File: rtl/dbuf_access_port.sv
module dbuf_access_port
    import dbuf_pkg::*;
#(
    parameter int unsigned NUM_BUFS = DBUF_NUM_BUFS,
    parameter int unsigned WORDS    = DBUF_WORDS,
    parameter int unsigned DATA_W   = DBUF_DATA_W,
    parameter int unsigned AUTO_BIT = DBUF_AUTO_BIT,
    parameter int unsigned SEL_LSB  = DBUF_SEL_LSB,
    localparam int unsigned SEL_W   = $clog2(NUM_BUFS),
    localparam int unsigned OFF_W   = $clog2(WORDS),
    localparam int unsigned LEN_W   = $clog2(WORDS * DATA_W / 8) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_req,
    input  logic              hst_wr,
    input  logic              hst_addr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              hst_rvalid,
    input  logic              crd_en,
    input  logic              crd_we,
    input  logic [SEL_W-1:0]  crd_buf,
    input  logic [OFF_W-1:0]  crd_word,
    input  logic [DATA_W-1:0] crd_wdata,
    output logic [DATA_W-1:0] crd_rdata,
    output logic              crd_conflict,
    input  logic [LEN_W-1:0]  xfer_bytes,
    output logic [OFF_W-1:0]  xfer_start_word
);
    typedef struct packed {
        logic             idx_rd;
        logic [SEL_W-1:0] h_bank;
        logic             h_rvalid;
        logic [SEL_W-1:0] c_bank;
        logic             c_blk;
        logic             conflict;
    } port_st_t;

    port_st_t st_d, st_q;

    logic             host_idx, host_data, idx_ld, clash;
    logic             idx_auto;
    logic [SEL_W-1:0] idx_sel;
    logic [OFF_W-1:0] idx_off;
    logic [DATA_W-1:0] idx_word;

    logic [NUM_BUFS-1:0] b_host, b_card, b_en, b_we;
    logic [OFF_W-1:0]    b_addr  [NUM_BUFS];
    logic [DATA_W-1:0]   b_wdata [NUM_BUFS];
    logic [DATA_W-1:0]   b_rdata [NUM_BUFS];

    assign host_idx  = hst_req && (hreg_e'(hst_addr) == HREG_INDEX);
    assign host_data = hst_req && (hreg_e'(hst_addr) == HREG_DATA);
    assign idx_ld    = host_idx && hst_wr;
    assign clash     = host_data && crd_en && (crd_buf == idx_sel);

    dbuf_index_reg #(.SEL_W(SEL_W), .OFF_W(OFF_W)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (idx_ld),
        .ld_auto (hst_wdata[AUTO_BIT]),
        .ld_sel  (hst_wdata[SEL_LSB +: SEL_W]),
        .ld_off  (hst_wdata[OFF_W-1:0]),
        .step    (host_data),
        .auto_o  (idx_auto),
        .sel_o   (idx_sel),
        .off_o   (idx_off)
    );

    for (genvar b = 0; b < NUM_BUFS; b++) begin : g_bank
        assign b_host[b]  = host_data && (idx_sel == SEL_W'(b));
        assign b_card[b]  = crd_en && (crd_buf == SEL_W'(b));
        assign b_en[b]    = b_host[b] || b_card[b];
        assign b_we[b]    = b_host[b] ? hst_wr    : crd_we;
        assign b_addr[b]  = b_host[b] ? idx_off   : crd_word;
        assign b_wdata[b] = b_host[b] ? hst_wdata : crd_wdata;

        dbuf_bank #(.WORDS(WORDS), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (b_en[b]),
            .we    (b_we[b]),
            .addr  (b_addr[b]),
            .wdata (b_wdata[b]),
            .rdata (b_rdata[b])
        );
    end

    dbuf_start_calc #(.WORDS(WORDS), .LEN_W(LEN_W)) u_start (
        .nbytes     (xfer_bytes),
        .start_word (xfer_start_word)
    );

    always_comb begin
        st_d          = st_q;
        st_d.h_rvalid = hst_req && !hst_wr;
        st_d.idx_rd   = host_idx && !hst_wr;
        if (host_data && !hst_wr) st_d.h_bank = idx_sel;
        if (crd_en && !crd_we) begin
            st_d.c_bank = crd_buf;
            st_d.c_blk  = clash;
        end
        st_d.conflict = clash;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        idx_word = '0;
        idx_word[AUTO_BIT]           = idx_auto;
        idx_word[SEL_LSB +: SEL_W]   = idx_sel;
        idx_word[OFF_W-1:0]          = idx_off;
        hst_rdata = st_q.idx_rd ? idx_word : b_rdata[st_q.h_bank];
        crd_rdata = st_q.c_blk ? '0 : b_rdata[st_q.c_bank];
    end

    assign hst_rvalid   = st_q.h_rvalid;
    assign crd_conflict = st_q.conflict;

    // R7
    rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_rvalid |-> $past(hst_req && !hst_wr));

    // R8
    conflict_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crd_conflict |-> $past(crd_en && hst_req && hst_addr && (crd_buf == idx_sel)));

    // R8
    conflict_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !crd_en |=> !crd_conflict);
endmodule

// File: tb/tb_dbuf_access_port.sv
module tb_dbuf_access_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        hst_req, hst_wr, hst_addr;
    logic [63:0] hst_wdata, hst_rdata;
    logic        hst_rvalid;
    logic        crd_en, crd_we, crd_buf;
    logic [5:0]  crd_word;
    logic [63:0] crd_wdata, crd_rdata;
    logic        crd_conflict;
    logic [9:0]  xfer_bytes;
    logic [5:0]  xfer_start_word;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [63:0] mem [2][64];
    logic        m_auto;
    logic        m_sel;
    logic [5:0]  m_off;

    always #4 clk = ~clk;

    dbuf_access_port dut (
        .clk(clk), .rst_n(rst_n),
        .hst_req(hst_req), .hst_wr(hst_wr), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid),
        .crd_en(crd_en), .crd_we(crd_we), .crd_buf(crd_buf), .crd_word(crd_word),
        .crd_wdata(crd_wdata), .crd_rdata(crd_rdata), .crd_conflict(crd_conflict),
        .xfer_bytes(xfer_bytes), .xfer_start_word(xfer_start_word)
    );

    function automatic logic [63:0] idxw(logic a, logic s, logic [5:0] o);
        return (64'(a) << 16) | (64'(s) << 6) | 64'(o);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; drives one cycle on both ports and checks the results
    task automatic run_cycle(string tag, bit h_req, bit h_wr, bit h_addr, logic [63:0] h_wd,
                             bit c_en, bit c_we, bit c_buf, logic [5:0] c_word, logic [63:0] c_wd);
        bit hdata, blk;
        logic [63:0] exp_h, exp_c;
        hdata = h_req && h_addr;
        blk   = hdata && c_en && (c_buf == m_sel);
        exp_h = h_addr ? mem[m_sel][m_off] : idxw(m_auto, m_sel, m_off);
        exp_c = blk ? 64'd0 : mem[c_buf][c_word];
        hst_req = h_req; hst_wr = h_wr; hst_addr = h_addr; hst_wdata = h_wd;
        crd_en = c_en; crd_we = c_we; crd_buf = c_buf; crd_word = c_word; crd_wdata = c_wd;
        if (hdata && h_wr) mem[m_sel][m_off] = h_wd;
        if (c_en && c_we && !blk) mem[c_buf][c_word] = c_wd;
        if (h_req && h_wr && !h_addr) begin
            m_auto = h_wd[16]; m_sel = h_wd[6]; m_off = h_wd[5:0];
        end else if (hdata && m_auto) begin
            m_off = m_off + 6'd1;
        end
        @(posedge clk);
        @(negedge clk);
        hst_req = 1'b0; hst_wr = 1'b0; crd_en = 1'b0; crd_we = 1'b0;
        chk({tag, " rvalid"}, 64'(hst_rvalid), 64'(h_req && !h_wr));
        if (h_req && !h_wr) chk({tag, " hst_rdata"}, hst_rdata, exp_h);
        if (c_en && !c_we)  chk({tag, " crd_rdata"}, crd_rdata, exp_c);
        chk({tag, " conflict"}, 64'(crd_conflict), 64'(blk));
    endtask

    task automatic idx_write(string tag, logic [63:0] v);
        run_cycle(tag, 1, 1, 0, v, 0, 0, 0, 6'd0, 64'd0);
    endtask
    task automatic idx_read(string tag);
        run_cycle(tag, 1, 0, 0, 64'd0, 0, 0, 0, 6'd0, 64'd0);
    endtask
    task automatic dat_write(string tag, logic [63:0] v);
        run_cycle(tag, 1, 1, 1, v, 0, 0, 0, 6'd0, 64'd0);
    endtask
    task automatic dat_read(string tag);
        run_cycle(tag, 1, 0, 1, 64'd0, 0, 0, 0, 6'd0, 64'd0);
    endtask
    task automatic crd_read(string tag, bit b, logic [5:0] w);
        run_cycle(tag, 0, 0, 0, 64'd0, 1, 0, b, w, 64'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 1'b0;
        hst_req = 0; hst_wr = 0; hst_addr = 0; hst_wdata = '0;
        crd_en = 0; crd_we = 0; crd_buf = 0; crd_word = '0; crd_wdata = '0;
        xfer_bytes = '0;
        m_auto = 0; m_sel = 0; m_off = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rvalid", 64'(hst_rvalid), 64'd0);
        chk("R1 conflict", 64'(crd_conflict), 64'd0);
        chk("R1 hst_rdata", hst_rdata, 64'd0);
        chk("R1 crd_rdata", crd_rdata, 64'd0);
        idx_read("R1 index");

        // R7 fill both buffers from the card side, read some back
        for (int b = 0; b < 2; b++)
            for (int w = 0; w < 64; w++)
                run_cycle("R7 fill", 0, 0, 0, 64'd0, 1, 1, b[0], w[5:0], {$urandom, $urandom});
        crd_read("R7", 0, 6'd0);
        crd_read("R7", 1, 6'd63);
        crd_read("R7", 1, 6'd17);

        // R2 field decode
        idx_write("R2", 64'h10000);
        idx_read("R2");
        idx_write("R2", 64'hFFFF_FFFF_FFFF_FF85);
        idx_read("R2");
        chk("R2 stray bits", hst_rdata, 64'h10005);
        idx_write("R2", 64'h00000000_000000C9);
        idx_read("R2");
        chk("R2 sel bit", hst_rdata, 64'h49);

        // R3 one word per access, first byte in the top lane
        idx_write("R3", 64'h10000);
        dat_write("R3", 64'h1122334455667788);
        crd_read("R3", 0, 6'd0);
        chk("R3 first byte lane", 64'(crd_rdata[63:56]), 64'h11);
        crd_read("R3 neighbour", 0, 6'd1);
        idx_write("R3", 64'h10000);
        dat_read("R3");
        dat_read("R3");

        // R5 wrap inside buffer 1
        idx_write("R5", 64'h1007E);
        dat_write("R5", 64'hA1A1_0000_0000_003E);
        dat_write("R5", 64'hA1A1_0000_0000_003F);
        dat_write("R5", 64'hA1A1_0000_0000_0000);
        idx_read("R5");
        chk("R5 wrapped index", hst_rdata, 64'h10041);
        crd_read("R5", 1, 6'd0);
        crd_read("R5", 1, 6'd63);
        crd_read("R5 buffer0 untouched", 0, 6'd0);

        // R4 no auto-increment
        idx_write("R4", 64'h3);
        dat_write("R4", 64'hDEAD_BEEF_0000_0003);
        dat_read("R4");
        idx_read("R4");
        chk("R4 offset held", hst_rdata, 64'h3);

        // R6 index reads leave the index alone
        idx_write("R6", 64'h1004A);
        idx_read("R6");
        idx_read("R6");
        chk("R6 after reads", hst_rdata, 64'h1004A);

        // R8 collisions
        idx_write("R8", 64'h4);
        run_cycle("R8 write clash", 1, 1, 1, 64'h0BAD_0000_0000_0001, 1, 1, 0, 6'd4, 64'hFFFF_0000_0000_0002);
        dat_read("R8 host won");
        crd_read("R8 host won", 0, 6'd4);
        run_cycle("R8 read clash", 1, 0, 1, 64'd0, 1, 0, 0, 6'd9, 64'd0);
        run_cycle("R8 other buffer", 1, 1, 1, 64'h7777_0000_0000_0005, 1, 1, 1, 6'd4, 64'h5555_0000_0000_0006);
        crd_read("R8 other buffer", 1, 6'd4);
        run_cycle("R8 idx and card", 1, 1, 0, 64'h10040, 1, 0, 1, 6'd4, 64'd0);

        // R9 start word
        begin
            int lens[5] = '{512, 8, 64, 256, 12};
            int exps[5] = '{0, 63, 56, 32, 62};
            for (int i = 0; i < 5; i++) begin
                xfer_bytes = lens[i][9:0];
                #1;
                chk("R9 start word", 64'(xfer_start_word), 64'(exps[i]));
            end
        end
        @(negedge clk);

        // random mix, R3/R4/R7/R8 through the model
        for (int n = 0; n < 1500; n++) begin
            int op;
            bit c_en, c_we, c_buf;
            logic [63:0] v;
            op    = int'($urandom % 8);
            c_en  = ($urandom % 2) == 0;
            c_we  = ($urandom % 2) == 0;
            c_buf = (($urandom % 2) == 0) ? m_sel : 1'($urandom);
            v     = {$urandom, $urandom};
            if (op == 0)
                run_cycle("R2 rnd", 1, 1, 0, v & 64'h0000_0000_0001_FFFF | (($urandom % 4 == 0) ? 64'h10000 : 64'h0) | 64'h10000 * (op & 0),
                          c_en, c_we, c_buf, 6'($urandom), {$urandom, $urandom});
            else if (op == 1)
                run_cycle("R6 rnd", 1, 0, 0, 64'd0, c_en, c_we, c_buf, 6'($urandom), {$urandom, $urandom});
            else if (op < 4)
                run_cycle("R3 rnd", 1, 1, 1, v, c_en, c_we, c_buf, 6'($urandom), {$urandom, $urandom});
            else if (op < 6)
                run_cycle("R4 rnd", 1, 0, 1, 64'd0, c_en, c_we, c_buf, 6'($urandom), {$urandom, $urandom});
            else
                run_cycle("R7 rnd", 0, 0, 0, 64'd0, c_en, c_we, c_buf, 6'($urandom), {$urandom, $urandom});
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule